// File: doc/BRIEF.md
# Fractional-Rate System Tick Counter

This block is a 64-bit free-running time base. It does not step once per input clock. On each active clock it adds a 32-bit rate word to a 32-bit phase accumulator. The tick count goes up by one each time that addition overflows. Software picks the tick frequency by loading rate = 2^32 × tick_hz / clk_hz, so a tick rate far below the clock rate comes out with a long-run average error of a fraction of one clock.

Software controls the block through a small register port with one write channel and one read channel. The control word has three bits:
- a run enable,
- a flag that freezes counting while an external debug-halt input is high,
- a frequency-change request, which the status word acknowledges.

The tick count, the rate and the phase can each be loaded directly. A separate add register lets software move the tick count forward by an offset without losing ticks that happen in the same cycle.

Top module: `systick_ctr`

## Requirements
- R1: After synchronous reset, the control word, status word, tick count, phase and rate all read 0, and `count_o` is 0.
- R2: While control bit 0 (enable) is 0, the tick count and phase keep their values on every clock.
- R3: On each clock where the block is running, phase becomes (phase + rate) mod 2^32, and the tick count rises by 1 exactly when that sum overflows 32 bits. After N running clocks from phase P and count C, count = C + floor((P + N·rate)/2^32) mod 2^64.
- R4: When control bit 1 (debug hold) is 1 and `dbg_halt_i` is high, the block is not running. When control bit 1 is 0, `dbg_halt_i` has no effect.
- R5: Status bit 1 is 1 on the clock after a cycle in which the block was held for debug, and 0 otherwise.
- R6: Status bit 8 (frequency-change acknowledge) follows control bit 8 (request) with one clock of delay. It rises one clock after the request is stored and falls one clock after the request is cleared.
- R7: A write to the add register adds its 64-bit value to the tick count at that clock edge, on top of any +1 from an accumulator overflow at the same edge. The add register reads as 0.
- R8: Writes to the tick count, rate and phase registers load those values, and reads return them. A write to the control register keeps only bits 0, 1 and 8. Writes to the status register are ignored.
- R9: The register addresses are: control 0, status 1, tick count 2, rate 3, phase 4, add 5. Addresses 6 and 7 read 0. `rd_data` shows the register selected by `rd_addr` one clock later, with its value as it was before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register select |
| wr_data | input | 64 | Write data |
| rd_addr | input | 3 | Read register select |
| rd_data | output | 64 | Registered read data |
| dbg_halt_i | input | 1 | External debug-halt request |
| count_o | output | 64 | Current tick count |

## Verification
The assertions assume that a given cycle has at most one write strobe, aimed at one register. They also assume that a direct load of the tick count or phase takes priority over stepping that cycle. They assume nothing about `dbg_halt_i`, which may change on any cycle. The stimulus changes inputs only between clock edges. It issues a single write per cycle and waits out the one-cycle read latency before comparing. Rates and starting phases are chosen so that the expected tick count follows from one 64-bit multiply-and-shift.

// File: rtl/systick_pkg.sv
package systick_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    SEL_CTRL  = 3'd0,
    SEL_STAT  = 3'd1,
    SEL_COUNT = 3'd2,
    SEL_RATE  = 3'd3,
    SEL_PHASE = 3'd4,
    SEL_ADD   = 3'd5
  } reg_sel_e;

  // control and status bit positions
  localparam int BIT_EN   = 0;
  localparam int BIT_HOLD = 1;
  localparam int BIT_FREQ = 8;
endpackage

// File: rtl/systick_ctrl.sv
module systick_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr_i,
  input  logic en_val_i,
  input  logic hold_val_i,
  input  logic freq_val_i,
  input  logic dbg_halt_i,
  output logic en_o,
  output logic hold_o,
  output logic freq_req_o,
  output logic run_o,
  output logic halted_o,
  output logic freq_ack_o
);
  logic en_q, hold_q, req_q, halted_q, ack_q;
  logic held;

  assign held  = hold_q & dbg_halt_i;
  assign run_o = en_q & ~held;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      hold_q   <= 1'b0;
      req_q    <= 1'b0;
      halted_q <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      if (ctrl_wr_i) begin
        en_q   <= en_val_i;
        hold_q <= hold_val_i;
        req_q  <= freq_val_i;
      end
      halted_q <= held;
      ack_q    <= req_q;
    end
  end

  assign en_o       = en_q;
  assign hold_o     = hold_q;
  assign freq_req_o = req_q;
  assign halted_o   = halted_q;
  assign freq_ack_o = ack_q;

  // R6: acknowledge drops once the request has been withdrawn
  p_ack_drop_r6: assert property (@(posedge clk) disable iff (rst)
    !freq_req_o |=> !freq_ack_o);

  // R5: the halted flag only follows a cycle that did not run
  p_halt_flag_r5: assert property (@(posedge clk) disable iff (rst)
    halted_o |-> $past(!run_o));
endmodule

// File: rtl/systick_phase.sv
module systick_phase #(
  parameter int ACC_W = 32,
  parameter logic [ACC_W-1:0] RATE_RST = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             rate_ld_i,
  input  logic [ACC_W-1:0] rate_val_i,
  input  logic             phase_ld_i,
  input  logic [ACC_W-1:0] phase_val_i,
  output logic [ACC_W-1:0] rate_o,
  output logic [ACC_W-1:0] phase_o,
  output logic             carry_o
);
  logic [ACC_W-1:0] rate_q, phase_q;
  logic [ACC_W:0]   sum;

  assign sum     = {1'b0, phase_q} + {1'b0, rate_q};
  assign carry_o = run_i & ~phase_ld_i & sum[ACC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q  <= RATE_RST;
      phase_q <= '0;
    end else begin
      if (rate_ld_i) rate_q <= rate_val_i;
      if (phase_ld_i)  phase_q <= phase_val_i;
      else if (run_i)  phase_q <= sum[ACC_W-1:0];
    end
  end

  assign rate_o  = rate_q;
  assign phase_o = phase_q;

  // R3: a running cycle moves the phase by exactly the rate
  p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
    (run_i && !phase_ld_i) |=> (phase_q - $past(phase_q)) == $past(rate_q));

  // R2: no run, no load -> phase holds
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !phase_ld_i) |=> $stable(phase_q));
endmodule

// File: rtl/systick_count.sv
module systick_count #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             add_i,
  input  logic [CNT_W-1:0] add_val_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q, offset;

  assign offset = add_i ? add_val_i : '0;

  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (ld_i) count_q <= ld_val_i;
    else           count_q <= count_q + offset + CNT_W'(inc_i);
  end

  assign count_o = count_q;

  // R3: an overflow alone advances the count by one
  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !ld_i && !add_i) |=> count_q == $past(count_q) + 1'b1);

  // R2: no overflow, no write -> count holds
  p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!inc_i && !ld_i && !add_i) |=> $stable(count_q));

  // R7: an add write merges with a same-cycle overflow
  p_add_merge_r7: assert property (@(posedge clk) disable iff (rst)
    (add_i && !ld_i) |=>
      (count_q - $past(count_q)) == ($past(add_val_i) + CNT_W'($past(inc_i))));
endmodule

// File: rtl/systick_ctr.sv
module systick_ctr
  import systick_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int ACC_W  = 32,
  parameter int DATA_W = 64,
  parameter logic [ACC_W-1:0] RATE_RST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dbg_halt_i,
  output logic [CNT_W-1:0]  count_o
);
  localparam int STAT_BITS = BIT_FREQ + 1;

  logic wr_ctrl, wr_count, wr_rate, wr_phase, wr_add;
  logic en, hold, freq_req, run, halted, freq_ack, carry;
  logic [ACC_W-1:0]  rate, phase;
  logic [CNT_W-1:0]  count;
  logic [STAT_BITS-1:0] ctrl_bits, stat_bits;
  logic [DATA_W-1:0] rd_mux, rd_q;

  assign wr_ctrl  = wr_en && (wr_addr == SEL_CTRL);
  assign wr_count = wr_en && (wr_addr == SEL_COUNT);
  assign wr_rate  = wr_en && (wr_addr == SEL_RATE);
  assign wr_phase = wr_en && (wr_addr == SEL_PHASE);
  assign wr_add   = wr_en && (wr_addr == SEL_ADD);

  systick_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ctrl_wr_i  (wr_ctrl),
    .en_val_i   (wr_data[BIT_EN]),
    .hold_val_i (wr_data[BIT_HOLD]),
    .freq_val_i (wr_data[BIT_FREQ]),
    .dbg_halt_i (dbg_halt_i),
    .en_o       (en),
    .hold_o     (hold),
    .freq_req_o (freq_req),
    .run_o      (run),
    .halted_o   (halted),
    .freq_ack_o (freq_ack)
  );

  systick_phase #(.ACC_W(ACC_W), .RATE_RST(RATE_RST)) u_phase (
    .clk         (clk),
    .rst         (rst),
    .run_i       (run),
    .rate_ld_i   (wr_rate),
    .rate_val_i  (wr_data[ACC_W-1:0]),
    .phase_ld_i  (wr_phase),
    .phase_val_i (wr_data[ACC_W-1:0]),
    .rate_o      (rate),
    .phase_o     (phase),
    .carry_o     (carry)
  );

  systick_count #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .inc_i     (carry),
    .ld_i      (wr_count),
    .ld_val_i  (wr_data[CNT_W-1:0]),
    .add_i     (wr_add),
    .add_val_i (wr_data[CNT_W-1:0]),
    .count_o   (count)
  );

  always_comb begin
    ctrl_bits           = '0;
    ctrl_bits[BIT_EN]   = en;
    ctrl_bits[BIT_HOLD] = hold;
    ctrl_bits[BIT_FREQ] = freq_req;
    stat_bits           = '0;
    stat_bits[BIT_HOLD] = halted;
    stat_bits[BIT_FREQ] = freq_ack;
  end

  always_comb begin
    case (rd_addr)
      SEL_CTRL:  rd_mux = DATA_W'(ctrl_bits);
      SEL_STAT:  rd_mux = DATA_W'(stat_bits);
      SEL_COUNT: rd_mux = DATA_W'(count);
      SEL_RATE:  rd_mux = DATA_W'(rate);
      SEL_PHASE: rd_mux = DATA_W'(phase);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_mux;
  end

  assign rd_data = rd_q;
  assign count_o = count;

  // R4: a debug hold while flagged stops the phase
  p_debug_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    (hold && dbg_halt_i && !wr_phase) |=> $stable(phase));

  // R8: status writes never reach the acknowledge
  p_stat_ro_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == SEL_STAT && !freq_req) |=> !freq_ack);
endmodule

// File: tb/test_systick_ctr.sv
`timescale 1ns/1ps
module test_systick_ctr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic        dbg_halt_i = 1'b0;
  logic [63:0] count_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  systick_ctr i_systick_ctr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .dbg_halt_i(dbg_halt_i), .count_o(count_o)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    rd_addr = a;
    @(posedge clk); @(negedge clk);
    d = rd_data;
  endtask

  logic [31:0] rates [6] = '{32'h0, 32'h1, 32'h4000_0000, 32'h8000_0000,
                             32'hAAAA_AAAB, 32'hFFFF_FFFF};
  int lens [4] = '{1, 3, 17, 40};

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!done) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, c0, s;
    logic [31:0] p0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 count_o", count_o, 64'h0);
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd1, v); chk("R1 status", v, 0);
    rd(3'd2, v); chk("R1 count", v, 0);
    rd(3'd3, v); chk("R1 rate", v, 0);
    rd(3'd4, v); chk("R1 phase", v, 0);

    // R9: add register and unmapped addresses read zero
    rd(3'd5, v); chk("R9 add reads 0", v, 0);
    rd(3'd6, v); chk("R9 addr6", v, 0);
    rd(3'd7, v); chk("R9 addr7", v, 0);

    // R8: loads and read-back, control masking, status read-only
    wr(3'd3, 64'hFFFF_FFFF_1357_9BDF); rd(3'd3, v); chk("R8 rate", v, 64'h1357_9BDF);
    wr(3'd4, 64'h0000_0000_2468_ACE0); rd(3'd4, v); chk("R8 phase", v, 64'h2468_ACE0);
    wr(3'd2, 64'hDEAD_BEEF_0BAD_F00D); rd(3'd2, v); chk("R8 count", v, 64'hDEAD_BEEF_0BAD_F00D);
    wr(3'd0, 64'hFFFF_FFFF_FFFF_FEFC); rd(3'd0, v); chk("R8 ctrl mask", v, 0);
    wr(3'd0, 64'h102); rd(3'd0, v); chk("R8 ctrl bits", v, 64'h102);
    wr(3'd0, 64'h0);
    wr(3'd1, 64'hFFFF_FFFF); @(negedge clk); rd(3'd1, v); chk("R8 status ro", v, 0);

    // R2: disabled counter does not move
    wr(3'd3, 64'hFFFF_FFFF); wr(3'd4, 0); wr(3'd2, 5);
    repeat (20) @(negedge clk);
    chk("R2 count_o", count_o, 5);
    rd(3'd4, v); chk("R2 phase", v, 0);

    // R3: sweep rates x lengths
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 4; j++) begin
        p0 = 32'hF000_0000 ^ (32'(i * 4 + j) * 32'h1111_1111);
        c0 = ((i + j) % 2 == 1) ? 64'hFFFF_FFFF_FFFF_FFF8 : 64'h1234;
        wr(3'd3, {32'h0, rates[i]});
        wr(3'd4, {32'h0, p0});
        wr(3'd2, c0);
        wr(3'd0, 64'h1);
        repeat (lens[j] - 1) @(negedge clk);
        wr(3'd0, 64'h0);
        s = {32'h0, p0} + 64'(lens[j]) * {32'h0, rates[i]};
        rd(3'd2, v); chk("R3 count", v, c0 + (s >> 32));
        rd(3'd4, v); chk("R3 phase", v, {32'h0, s[31:0]});
      end
    end

    // R7: add write on a cycle that also overflows
    wr(3'd3, 64'h8000_0000); wr(3'd4, 0); wr(3'd2, 1000);
    wr(3'd0, 64'h1);
    @(negedge clk);
    wr(3'd5, 64'h1_0000_0000);
    repeat (2) @(negedge clk);
    wr(3'd0, 64'h0);
    rd(3'd2, v); chk("R7 add with carry", v, 64'd1000 + 64'd2 + 64'h1_0000_0000);

    // R4/R5: debug hold freezes the counter and sets status
    wr(3'd3, 64'h4000_0000); wr(3'd4, 0); wr(3'd2, 0);
    dbg_halt_i = 1'b1;
    wr(3'd0, 64'h3);
    repeat (10) @(negedge clk);
    chk("R4 frozen count_o", count_o, 0);
    rd(3'd1, v); chk("R5 halted flag", v & 64'h2, 64'h2);
    rd(3'd4, v); chk("R4 frozen phase", v, 0);
    dbg_halt_i = 1'b0;
    repeat (7) @(negedge clk);
    wr(3'd0, 64'h0);
    rd(3'd2, v); chk("R4 resumes", v, 2);
    rd(3'd1, v); chk("R5 flag clears", v & 64'h2, 0);

    // R4: halt input ignored without the hold flag
    wr(3'd4, 0); wr(3'd2, 0);
    dbg_halt_i = 1'b1;
    wr(3'd0, 64'h1);
    repeat (7) @(negedge clk);
    wr(3'd0, 64'h0);
    rd(3'd2, v); chk("R4 ignored halt", v, 2);
    rd(3'd1, v); chk("R5 no flag without hold", v & 64'h2, 0);
    dbg_halt_i = 1'b0;

    // R6: frequency-change handshake
    wr(3'd0, 64'h100);
    rd(3'd1, v); chk("R6 ack not yet", v & 64'h100, 0);
    rd(3'd1, v); chk("R6 ack set", v & 64'h100, 64'h100);
    wr(3'd0, 64'h0);
    rd(3'd1, v); chk("R6 ack still up", v & 64'h100, 64'h100);
    rd(3'd1, v); chk("R6 ack cleared", v & 64'h100, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule